// File: doc/BRIEF.md
# Processor bus hold and backoff controller

This block decides who owns a processor's external bus. It follows the bus cycles that a cycle generator starts, counting burst-ready strobes until each cycle's final transfer. It also answers three outside requests for the bus. A full hold request waits for any cycle in progress to finish, then acknowledges and floats every bus-driving group. An address-only hold request floats just the address group and lets the cycle run on. A backoff request ends the cycle in progress at once.

A backoff that ends a cycle gives a one-clock abort pulse and sets a restart-pending flag. Once backoff is removed, the block starts the cycle again from its first transfer by itself. The cycle generator is modelled by two inputs: a start strobe and a burst-length bit. The two output-enable signals are meant to drive the tristate controls of the address pads and of the remaining pads (data, strobes, byte enables, cycle attributes, parity).

Top module: `bus_release_ctrl`

## Requirements
- R1: After reset the bus is driven (`addr_oe`=1, `bus_oe`=1), and `hold_ack`, `cyc_busy`, `abort_pulse` and `restart_pend` are all 0.
- R2: A `cyc_start` sampled while the bus is idle and no request is pending sets `cyc_busy` from the next edge. The cycle ends at the edge that samples its last `brdy`. That is the first `brdy` when `cyc_burst`=0, and the `BURST_BEATS`-th (default 4) when `cyc_burst`=1.
- R3: A `hold_req` sampled during a cycle does not cut it short. `hold_ack` stays 0 until the edge that samples the final `brdy`. From that edge, `hold_ack`=1 and both enables are 0.
- R4: A `hold_req` sampled with no cycle in progress gives `hold_ack`=1 and both enables 0 from the next edge.
- R5: While `hold_req` stays high, `hold_ack` stays 1 and both enables stay 0.
- R6: When `hold_req` is sampled low, `hold_ack` falls and both enables return to 1 on that edge. A `cyc_start` presented in that same clock is not taken.
- R7: An `ahold_req` sampled high clears `addr_oe` from the next edge only. `bus_oe` stays 1, `hold_ack` stays 0, and a cycle in progress still completes. No new cycle starts while `ahold_req` is high.
- R8: A `boff_req` sampled during a cycle ends it on that edge: `cyc_busy`=0, both enables 0, `abort_pulse`=1 for exactly one clock, and `restart_pend`=1.
- R9: When `boff_req` is sampled low, the enables return to 1 on that edge. On the following edge the aborted cycle starts again with its full transfer count, and `restart_pend` clears.
- R10: When `boff_req` and `hold_req` are both sampled in the same clock, backoff wins: `hold_ack` stays 0 and the bus floats.
- R11: A `brdy` sampled while held or backed off has no effect. It does not end a cycle, and it does not shorten a restarted one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start | input | 1 | Cycle generator asks to begin a bus cycle |
| cyc_burst | input | 1 | 1: burst cycle of BURST_BEATS transfers, 0: single transfer |
| brdy | input | 1 | Burst-ready strobe, one per completed transfer |
| hold_req | input | 1 | Full bus hold request |
| ahold_req | input | 1 | Address-only hold request |
| boff_req | input | 1 | Backoff request |
| hold_ack | output | 1 | Hold acknowledge |
| addr_oe | output | 1 | Output enable for the address group |
| bus_oe | output | 1 | Output enable for all other bus-driving groups |
| cyc_busy | output | 1 | A bus cycle is in progress |
| abort_pulse | output | 1 | One-clock pulse when backoff ends a cycle |
| restart_pend | output | 1 | An aborted cycle waits to be reissued |

## Verification
The assertions assume that every input is a clean synchronous level, 0 from reset onward and never X. They also assume that `cyc_start` is not raised while a reissue is pending, so that the restarted cycle is the only one in flight. The stimulus drives every input just after a rising edge from named scenario tasks and returns each request to 0 before the task ends. Every scenario starts and ends with the bus idle, so no scenario inherits a pending restart or a held bus.

// File: rtl/bus_release_ctrl.sv
module bus_release_ctrl #(
  parameter int BURST_BEATS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_start,
  input  logic cyc_burst,
  input  logic brdy,
  input  logic hold_req,
  input  logic ahold_req,
  input  logic boff_req,
  output logic hold_ack,
  output logic addr_oe,
  output logic bus_oe,
  output logic cyc_busy,
  output logic abort_pulse,
  output logic restart_pend
);
  localparam int CW = $clog2(BURST_BEATS + 1);

  typedef enum logic [1:0] {S_IDLE, S_ACTIVE, S_HELD, S_BACKOFF} own_t;

  own_t          st;
  logic [CW-1:0] beats_left;
  logic          burst_q, ahold_q, abort_q, restart_q;

  wire can_start = (st == S_IDLE) && !hold_req && !ahold_req && !boff_req;
  wire go        = can_start && (restart_q || cyc_start);
  wire go_burst  = restart_q ? burst_q : cyc_burst;
  wire released  = (st == S_HELD) || (st == S_BACKOFF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      beats_left <= '0;
      burst_q    <= 1'b0;
      ahold_q    <= 1'b0;
      abort_q    <= 1'b0;
      restart_q  <= 1'b0;
    end else begin
      ahold_q <= ahold_req;
      abort_q <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (boff_req)      st <= S_BACKOFF;
          else if (hold_req) st <= S_HELD;
          else if (go) begin
            st         <= S_ACTIVE;
            beats_left <= go_burst ? CW'(BURST_BEATS) : CW'(1);
            burst_q    <= go_burst;
            restart_q  <= 1'b0;
          end
        end
        S_ACTIVE: begin
          if (boff_req) begin
            st        <= S_BACKOFF;
            abort_q   <= 1'b1;
            restart_q <= 1'b1;
          end else if (brdy) begin
            if (beats_left == CW'(1)) st <= hold_req ? S_HELD : S_IDLE;
            else                      beats_left <= beats_left - CW'(1);
          end
        end
        S_HELD: begin
          if (boff_req)       st <= S_BACKOFF;
          else if (!hold_req) st <= S_IDLE;
        end
        S_BACKOFF: begin
          if (!boff_req) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign hold_ack     = (st == S_HELD);
  assign cyc_busy     = (st == S_ACTIVE);
  assign bus_oe       = !released;
  assign addr_oe      = !released && !ahold_q;
  assign abort_pulse  = abort_q;
  assign restart_pend = restart_q;

  p_ack_floats_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack |-> (!addr_oe && !bus_oe));

  p_no_ack_mid_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_busy |-> !hold_ack);

  p_abort_sets_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> (restart_pend && !cyc_busy && !bus_oe));

  p_abort_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |=> !abort_pulse);

  p_boff_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    boff_req |=> (!hold_ack && !bus_oe && !cyc_busy));

  p_hold_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_ack && !hold_req && !boff_req) |=> (!hold_ack && bus_oe && !cyc_busy));

  p_ahold_addr_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ahold_req && !hold_req && !boff_req) |=> (!addr_oe && bus_oe && !hold_ack));
endmodule

// File: tb/bus_release_ctrl_tb.sv
module bus_release_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cyc_start = 0, cyc_burst = 0, brdy = 0, hold_req = 0, ahold_req = 0, boff_req = 0;
  logic hold_ack, addr_oe, bus_oe, cyc_busy, abort_pulse, restart_pend;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  bus_release_ctrl #(.BURST_BEATS(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_burst(cyc_burst),
    .brdy(brdy), .hold_req(hold_req), .ahold_req(ahold_req), .boff_req(boff_req),
    .hold_ack(hold_ack), .addr_oe(addr_oe), .bus_oe(bus_oe), .cyc_busy(cyc_busy),
    .abort_pulse(abort_pulse), .restart_pend(restart_pend));

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    chk("R1", "addr_oe", addr_oe, 1); chk("R1", "bus_oe", bus_oe, 1);
    chk("R1", "hold_ack", hold_ack, 0); chk("R1", "cyc_busy", cyc_busy, 0);
    chk("R1", "abort_pulse", abort_pulse, 0); chk("R1", "restart_pend", restart_pend, 0);
  endtask

  task automatic t_single_and_burst();
    cyc_start = 1; cyc_burst = 0; tick(); cyc_start = 0;
    chk("R2", "single busy", cyc_busy, 1);
    brdy = 1; tick(); brdy = 0;
    chk("R2", "single done", cyc_busy, 0);
    cyc_start = 1; cyc_burst = 1; tick(); cyc_start = 0;
    brdy = 1;
    for (int i = 0; i < 3; i++) begin
      tick(); chk("R2", "burst mid", cyc_busy, 1);
    end
    tick(); brdy = 0;
    chk("R2", "burst done", cyc_busy, 0);
  endtask

  task automatic t_hold_in_cycle();
    cyc_start = 1; cyc_burst = 1; tick(); cyc_start = 0;
    hold_req = 1; brdy = 1;
    for (int i = 0; i < 3; i++) begin
      tick(); chk("R3", "no early ack", hold_ack, 0); chk("R3", "still busy", cyc_busy, 1);
    end
    tick();
    chk("R3", "ack after last brdy", hold_ack, 1);
    chk("R3", "addr float", addr_oe, 0); chk("R3", "bus float", bus_oe, 0);
    for (int i = 0; i < 3; i++) begin
      tick(); chk("R5", "ack held", hold_ack, 1); chk("R5", "float held", bus_oe, 0);
      chk("R11", "brdy ignored", cyc_busy, 0);
    end
    brdy = 0; hold_req = 0; cyc_start = 1; tick();
    chk("R6", "ack drop", hold_ack, 0); chk("R6", "bus driven", bus_oe, 1);
    chk("R6", "addr driven", addr_oe, 1); chk("R6", "start ignored", cyc_busy, 0);
    cyc_start = 0; tick();
    chk("R6", "no late start", cyc_busy, 0);
  endtask

  task automatic t_hold_idle();
    hold_req = 1; tick();
    chk("R4", "idle ack", hold_ack, 1); chk("R4", "idle float", bus_oe, 0);
    hold_req = 0; tick();
    chk("R6", "idle release", hold_ack, 0);
  endtask

  task automatic t_ahold();
    cyc_start = 1; cyc_burst = 0; tick(); cyc_start = 0;
    ahold_req = 1; tick();
    chk("R7", "addr float", addr_oe, 0); chk("R7", "bus driven", bus_oe, 1);
    chk("R7", "no ack", hold_ack, 0); chk("R7", "cycle continues", cyc_busy, 1);
    brdy = 1; tick(); brdy = 0;
    chk("R7", "cycle completes", cyc_busy, 0); chk("R7", "addr still float", addr_oe, 0);
    cyc_start = 1; tick();
    chk("R7", "start blocked", cyc_busy, 0);
    ahold_req = 0; tick(); cyc_start = 0;
    chk("R7", "start after ahold", cyc_busy, 1); chk("R7", "addr back", addr_oe, 1);
    brdy = 1; tick(); brdy = 0;
    chk("R2", "done", cyc_busy, 0);
  endtask

  task automatic t_backoff();
    cyc_start = 1; cyc_burst = 1; tick(); cyc_start = 0;
    brdy = 1; tick(); brdy = 0;
    boff_req = 1; tick();
    chk("R8", "busy cleared", cyc_busy, 0); chk("R8", "bus float", bus_oe, 0);
    chk("R8", "addr float", addr_oe, 0); chk("R8", "abort", abort_pulse, 1);
    chk("R8", "restart pend", restart_pend, 1);
    brdy = 1; tick();
    chk("R8", "abort one clock", abort_pulse, 0);
    chk("R11", "brdy in backoff", cyc_busy, 0);
    brdy = 0; boff_req = 0; tick();
    chk("R9", "bus driven", bus_oe, 1); chk("R9", "still pending", restart_pend, 1);
    tick();
    chk("R9", "reissued", cyc_busy, 1); chk("R9", "pend cleared", restart_pend, 0);
    brdy = 1;
    for (int i = 0; i < 3; i++) begin
      tick(); chk("R11", "full length", cyc_busy, 1);
    end
    tick(); brdy = 0;
    chk("R9", "reissue done", cyc_busy, 0);
  endtask

  task automatic t_priority();
    hold_req = 1; boff_req = 1; tick();
    chk("R10", "no ack", hold_ack, 0); chk("R10", "float", bus_oe, 0);
    chk("R10", "no abort when idle", abort_pulse, 0);
    boff_req = 0; tick();
    chk("R10", "still no ack", hold_ack, 0);
    tick();
    chk("R4", "hold after boff", hold_ack, 1);
    hold_req = 0; tick();
    chk("R6", "released", bus_oe, 1);
  endtask

  initial begin
    #400000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    tick(); tick(); rst_n = 1; tick();
    t_reset();
    t_single_and_burst();
    t_hold_in_cycle();
    t_hold_idle();
    t_ahold();
    t_backoff();
    t_priority();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule